// File: doc/BRIEF.md
# E1 Sa-Bit Synchronization Status Receive Validator

This block sits behind an E1 receive framer that has already found frame and CRC4 multiframe alignment. For every received frame it takes the timeslot-0 byte together with that frame's index (0 to 15) inside the multiframe. It collects the spare and international bits of all sixteen frames into eight 8-bit capture registers. These registers are refreshed together at the end of each multiframe and marked by a one-cycle boundary pulse. Host logic then has a full 2 ms multiframe to read them before they are overwritten.

In parallel, one configurable Sa bit (Sa4 to Sa8) is treated as the carrier of a 4-bit synchronization status message. One message arrives in each 8-frame half of the multiframe. A new quality level replaces the validated one only after three consecutive halves carry the same code. Any change of the validated code raises a sticky interrupt that the host clears. A loss-of-multiframe-alignment input throws away all partial state, so that nothing assembled across a realignment is ever reported.

Top module: `e1_ssm_rx`

## Requirements
- R1: Bit 1 of timeslot 0 is `frm_byte[7]`. In even frames (alignment frames) that bit is captured as Si. In odd frames `frm_byte[7]` is captured as Si, `frm_byte[5]` as RA, and `frm_byte[4]`, `[3]`, `[2]`, `[1]`, `[0]` as Sa4, Sa5, Sa6, Sa7, Sa8.
- R2: Each capture register holds the eight bits of one multiframe, with the bit from the earliest frame in bit 7. All eight registers update together, and only at the end of frame 15. At all other times they hold their value.
- R3: `mf_pulse` is high for exactly one cycle, in the cycle after frame 15 is strobed. In that cycle the capture registers already show the new multiframe.
- R4: `sa_sel` values 0, 1, 2, 3 and 4 select Sa4, Sa5, Sa6, Sa7 and Sa8 as the message carrier. Values 5 to 7 also select Sa8.
- R5: A message is the selected Sa bit of the four odd frames of one half-multiframe (frames 1, 3, 5, 7 or frames 9, 11, 13, 15). The bit of the earliest frame is the MSB.
- R6: `ssm_q` takes a new code only when three consecutive half-multiframe messages are identical. A message that differs from the previous one restarts the count.
- R7: `ssm_irq` is set when `ssm_q` changes value. It is not set when an already validated code is confirmed again. It stays set until `irq_clr` is pulsed.
- R8: After reset, `ssm_q` is 4'b1111, `ssm_irq` and `mf_pulse` are low, and all capture registers are zero.
- R9: `mfa_lost` clears the agreement count, the partial message and the capture shift state. No capture update or boundary pulse occurs until a multiframe that starts at frame 0 after the loss has been fully received.
- R10: `ssm_defined` is high when `ssm_q` is 0, 2, 4, 8, 11 or 15. Reserved codes are still validated and reported on `ssm_q`, with `ssm_defined` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_stb | input | 1 | One-cycle strobe: `frm_byte` and `frm_pos` are valid |
| frm_pos | input | 4 | Frame index inside the CRC4 multiframe |
| frm_byte | input | 8 | Received timeslot-0 byte, bit 7 is the first bit on the line |
| mfa_lost | input | 1 | Loss of multiframe alignment |
| sa_sel | input | 3 | Sa bit carrying the status message |
| irq_clr | input | 1 | Clears the change interrupt |
| si_fas_reg | output | 8 | Si bits of the alignment frames |
| si_nfas_reg | output | 8 | Si bits of the non-alignment frames |
| ra_reg | output | 8 | Remote alarm bits |
| sa4_reg | output | 8 | Sa4 bits |
| sa5_reg | output | 8 | Sa5 bits |
| sa6_reg | output | 8 | Sa6 bits |
| sa7_reg | output | 8 | Sa7 bits |
| sa8_reg | output | 8 | Sa8 bits |
| mf_pulse | output | 1 | Multiframe boundary, capture registers refreshed |
| ssm_q | output | 4 | Validated quality level |
| ssm_defined | output | 1 | Validated code is one of the defined levels |
| ssm_irq | output | 1 | Sticky change-of-quality interrupt |

## Verification
On every cycle the assertions check these properties:
- The interrupt stays set until cleared.
- A change of the validated code always comes with the interrupt and follows an assembled message.
- Capture registers move only with the boundary pulse.
- The pulse lasts one cycle, follows frame 15, and is suppressed by a loss of alignment.

The bench scenarios show the rest:
- Bit mapping into each capture register, and the choice of carrier bit.
- The three-message agreement rule, including restarts, re-confirmation of the current code and reserved codes.
- Recovery after an alignment loss in the middle of a multiframe.

// File: rtl/e1_ssm_pkg.sv
// Shared constants and helpers for the E1 status message receive path.
// Assumes a 16-frame CRC4 multiframe split into two 8-frame halves.
package e1_ssm_pkg;
    localparam int FRAMES_PER_MF = 16;
    localparam int POS_W         = $clog2(FRAMES_PER_MF);
    localparam int HALF_LEN      = FRAMES_PER_MF / 2;
    localparam int CAP_W         = FRAMES_PER_MF / 2;   // one bit per odd (or even) frame
    localparam int SSM_W         = HALF_LEN / 2;        // odd frames per half multiframe
    localparam int SA_CNT        = 5;                   // Sa4 .. Sa8
    localparam int NF_CH         = SA_CNT + 2;          // Si, RA, Sa4..Sa8 of odd frames
    localparam int SEL_W         = 3;

    // Channel order of the odd-frame capture array (highest index = Si)
    localparam int CH_SI = NF_CH - 1;
    localparam int CH_RA = NF_CH - 2;

    // Quality levels treated as defined; all others are reserved
    function automatic logic code_defined(input logic [SSM_W-1:0] code);
        case (code)
            4'd0, 4'd2, 4'd4, 4'd8, 4'd11, 4'd15: code_defined = 1'b1;
            default:                              code_defined = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/e1_ts0_capture.sv
// Collects Si, RA and Sa4..Sa8 of one CRC4 multiframe into shift registers
// and commits them as a set at the end of frame 15.
// Assumes frm_pos is already aligned by an upstream framer; a commit only
// happens once frame 0 has been seen since the last loss of alignment.
module e1_ts0_capture
    import e1_ssm_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frm_stb,
    input  logic [POS_W-1:0]            frm_pos,
    input  logic [7:0]                  frm_byte,
    input  logic                        mfa_lost,
    output logic [CAP_W-1:0]            cap_fas,
    output logic [NF_CH-1:0][CAP_W-1:0] cap_nf,
    output logic                        mf_pulse
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAMES_PER_MF - 1);

    logic                        armed;
    logic [CAP_W-1:0]            fas_sh;
    logic [NF_CH-1:0][CAP_W-1:0] nf_sh;
    logic [NF_CH-1:0]            nf_bits;
    logic                        is_odd;
    logic                        commit;

    // Odd-frame bit sources: Si, RA, then Sa4..Sa8 down to channel 0
    always_comb begin
        nf_bits                = '0;
        nf_bits[CH_SI]         = frm_byte[7];
        nf_bits[CH_RA]         = frm_byte[5];
        nf_bits[SA_CNT-1:0]    = frm_byte[SA_CNT-1:0];
    end

    assign is_odd = frm_pos[0];
    assign commit = frm_stb && (frm_pos == LAST_POS) && armed && !mfa_lost;

    // Arms the commit once a multiframe starts at frame 0
    always_ff @(posedge clk) begin
        if (!rst_n)                        armed <= 1'b0;
        else if (mfa_lost)                 armed <= 1'b0;
        else if (frm_stb && frm_pos == '0) armed <= 1'b1;
    end

    // Shifts the Si bit of alignment frames, earliest bit ends in the MSB
    always_ff @(posedge clk) begin
        if (!rst_n)                  fas_sh <= '0;
        else if (mfa_lost)           fas_sh <= '0;
        else if (frm_stb && !is_odd) fas_sh <= {fas_sh[CAP_W-2:0], frm_byte[7]};
    end

    // Commits the alignment-frame Si register at the multiframe end
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_fas <= '0;
        else if (commit) cap_fas <= fas_sh;
    end

    genvar ch;
    generate
        for (ch = 0; ch < NF_CH; ch++) begin : g_nf
            // Shifts one odd-frame bit position per multiframe
            always_ff @(posedge clk) begin
                if (!rst_n)                 nf_sh[ch] <= '0;
                else if (mfa_lost)          nf_sh[ch] <= '0;
                else if (frm_stb && is_odd) nf_sh[ch] <= {nf_sh[ch][CAP_W-2:0], nf_bits[ch]};
            end

            // Commits the channel including the frame-15 bit
            always_ff @(posedge clk) begin
                if (!rst_n)      cap_nf[ch] <= '0;
                else if (commit) cap_nf[ch] <= {nf_sh[ch][CAP_W-2:0], nf_bits[ch]};
            end
        end
    endgenerate

    // Boundary pulse coincides with the refreshed registers
    always_ff @(posedge clk) begin
        if (!rst_n) mf_pulse <= 1'b0;
        else        mf_pulse <= commit;
    end
endmodule

// File: rtl/e1_ssm_assemble.sv
// Picks the selected Sa bit from odd frames and assembles one message per
// half multiframe, earliest bit as MSB. A message is emitted only if all
// odd frames of the half were seen in order since the last realignment.
module e1_ssm_assemble
    import e1_ssm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_stb,
    input  logic [POS_W-1:0]  frm_pos,
    input  logic [7:0]        frm_byte,
    input  logic [SEL_W-1:0]  sa_sel,
    input  logic              mfa_lost,
    output logic              msg_stb,
    output logic [SSM_W-1:0]  msg
);
    localparam int SUB_W = $clog2(HALF_LEN);
    localparam int CNT_W = $clog2(SSM_W) + 1;
    localparam logic [SUB_W-1:0] FIRST_ODD = SUB_W'(1);
    localparam logic [SUB_W-1:0] LAST_ODD  = SUB_W'(HALF_LEN - 1);

    logic [SUB_W-1:0] sub_pos;
    logic [2:0]       bit_idx;
    logic             sa_bit;
    logic [SSM_W-1:0] sh;
    logic [CNT_W-1:0] cnt;

    assign sub_pos = frm_pos[SUB_W-1:0];

    // Maps the selector onto the byte position, out-of-range picks Sa8
    always_comb begin
        if (sa_sel >= SEL_W'(SA_CNT)) bit_idx = 3'd0;
        else                          bit_idx = 3'(SA_CNT - 1) - 3'(sa_sel);
        sa_bit = frm_byte[bit_idx];
    end

    // Builds the message and emits it on the last odd frame of each half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            cnt     <= '0;
            msg     <= '0;
            msg_stb <= 1'b0;
        end else begin
            msg_stb <= 1'b0;
            if (mfa_lost) begin
                sh  <= '0;
                cnt <= '0;
            end else if (frm_stb && frm_pos[0]) begin
                if (sub_pos == FIRST_ODD) begin
                    sh  <= {{(SSM_W-1){1'b0}}, sa_bit};
                    cnt <= CNT_W'(1);
                end else if (sub_pos == LAST_ODD) begin
                    if (cnt == CNT_W'(SSM_W - 1)) begin
                        msg     <= {sh[SSM_W-2:0], sa_bit};
                        msg_stb <= 1'b1;
                    end
                    sh  <= '0;
                    cnt <= '0;
                end else if (cnt != '0) begin
                    sh  <= {sh[SSM_W-2:0], sa_bit};
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/e1_ssm_validate.sv
// Accepts a quality level after AGREE_CNT identical consecutive messages
// and raises a sticky interrupt whenever the accepted level changes.
// Assumes msg_stb is a single-cycle strobe from the assembler.
module e1_ssm_validate
    import e1_ssm_pkg::*;
#(
    parameter int AGREE_CNT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_stb,
    input  logic [SSM_W-1:0] msg,
    input  logic             mfa_lost,
    input  logic             irq_clr,
    output logic [SSM_W-1:0] ssm_q,
    output logic             ssm_irq
);
    localparam int CW = $clog2(AGREE_CNT + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(AGREE_CNT);

    logic [SSM_W-1:0] cand;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    cnt_nxt;
    logic             accept;
    logic             changed;

    // Next agreement count for an incoming message
    always_comb begin
        if (cnt != '0 && msg == cand)
            cnt_nxt = (cnt >= CNT_MAX) ? CNT_MAX : cnt + CW'(1);
        else
            cnt_nxt = CW'(1);
        accept  = msg_stb && !mfa_lost && (cnt_nxt >= CNT_MAX);
        changed = accept && (msg != ssm_q);
    end

    // Tracks the candidate code and how often it has repeated
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand <= '0;
            cnt  <= '0;
        end else if (mfa_lost) begin
            cnt  <= '0;
        end else if (msg_stb) begin
            cand <= msg;
            cnt  <= cnt_nxt;
        end
    end

    // Holds the validated level, starting at "do not use"
    always_ff @(posedge clk) begin
        if (!rst_n)       ssm_q <= '1;
        else if (changed) ssm_q <= msg;
    end

    // Sticky change interrupt, a new change wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)       ssm_irq <= 1'b0;
        else if (changed) ssm_irq <= 1'b1;
        else if (irq_clr) ssm_irq <= 1'b0;
    end
endmodule

// File: rtl/e1_ssm_rx.sv
// Top of the E1 Sa-bit status receive path: capture registers, message
// assembly and validation. Assumes aligned frame positions from a framer.
module e1_ssm_rx
    import e1_ssm_pkg::*;
#(
    parameter int AGREE_CNT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_stb,
    input  logic [POS_W-1:0] frm_pos,
    input  logic [7:0]       frm_byte,
    input  logic             mfa_lost,
    input  logic [SEL_W-1:0] sa_sel,
    input  logic             irq_clr,
    output logic [CAP_W-1:0] si_fas_reg,
    output logic [CAP_W-1:0] si_nfas_reg,
    output logic [CAP_W-1:0] ra_reg,
    output logic [CAP_W-1:0] sa4_reg,
    output logic [CAP_W-1:0] sa5_reg,
    output logic [CAP_W-1:0] sa6_reg,
    output logic [CAP_W-1:0] sa7_reg,
    output logic [CAP_W-1:0] sa8_reg,
    output logic             mf_pulse,
    output logic [SSM_W-1:0] ssm_q,
    output logic             ssm_defined,
    output logic             ssm_irq
);
    logic [NF_CH-1:0][CAP_W-1:0] cap_nf;
    logic                        asm_stb;
    logic [SSM_W-1:0]            asm_msg;

    e1_ts0_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_stb  (frm_stb),
        .frm_pos  (frm_pos),
        .frm_byte (frm_byte),
        .mfa_lost (mfa_lost),
        .cap_fas  (si_fas_reg),
        .cap_nf   (cap_nf),
        .mf_pulse (mf_pulse)
    );

    e1_ssm_assemble u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_stb  (frm_stb),
        .frm_pos  (frm_pos),
        .frm_byte (frm_byte),
        .sa_sel   (sa_sel),
        .mfa_lost (mfa_lost),
        .msg_stb  (asm_stb),
        .msg      (asm_msg)
    );

    e1_ssm_validate #(.AGREE_CNT(AGREE_CNT)) u_val (
        .clk      (clk),
        .rst_n    (rst_n),
        .msg_stb  (asm_stb),
        .msg      (asm_msg),
        .mfa_lost (mfa_lost),
        .irq_clr  (irq_clr),
        .ssm_q    (ssm_q),
        .ssm_irq  (ssm_irq)
    );

    // Splits the odd-frame capture array onto named registers
    assign si_nfas_reg = cap_nf[CH_SI];
    assign ra_reg      = cap_nf[CH_RA];
    assign sa4_reg     = cap_nf[4];
    assign sa5_reg     = cap_nf[3];
    assign sa6_reg     = cap_nf[2];
    assign sa7_reg     = cap_nf[1];
    assign sa8_reg     = cap_nf[0];

    assign ssm_defined = code_defined(ssm_q);
endmodule

// File: rtl/e1_ssm_rx_chk.sv
// Protocol checker for e1_ssm_rx, attached by bind.
module e1_ssm_rx_chk
    import e1_ssm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             frm_stb,
    input logic [POS_W-1:0] frm_pos,
    input logic             mfa_lost,
    input logic             irq_clr,
    input logic [8*CAP_W-1:0] caps,
    input logic             mf_pulse,
    input logic [SSM_W-1:0] ssm_q,
    input logic             ssm_irq,
    input logic             asm_stb
);
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ssm_irq && !irq_clr |=> ssm_irq);

    p_change_raises_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ssm_q) |-> ssm_irq);

    p_change_needs_msg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ssm_q) |-> $past(asm_stb));

    p_pulse_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mf_pulse |-> $past(frm_stb && frm_pos == POS_W'(FRAMES_PER_MF - 1)));

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mf_pulse |=> !mf_pulse);

    p_cap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(caps) |-> mf_pulse);

    p_lost_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mfa_lost |=> !mf_pulse);
endmodule

bind e1_ssm_rx e1_ssm_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_stb  (frm_stb),
    .frm_pos  (frm_pos),
    .mfa_lost (mfa_lost),
    .irq_clr  (irq_clr),
    .caps     ({si_fas_reg, si_nfas_reg, ra_reg, sa4_reg, sa5_reg, sa6_reg, sa7_reg, sa8_reg}),
    .mf_pulse (mf_pulse),
    .ssm_q    (ssm_q),
    .ssm_irq  (ssm_irq),
    .asm_stb  (asm_stb)
);

// File: tb/tb_e1_ssm_rx.sv
`timescale 1ns/1ps
module tb_e1_ssm_rx;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       frm_stb;
    logic [3:0] frm_pos;
    logic [7:0] frm_byte;
    logic       mfa_lost;
    logic [2:0] sa_sel;
    logic       irq_clr;
    logic [7:0] si_fas_reg, si_nfas_reg, ra_reg;
    logic [7:0] sa4_reg, sa5_reg, sa6_reg, sa7_reg, sa8_reg;
    logic       mf_pulse;
    logic [3:0] ssm_q;
    logic       ssm_defined;
    logic       ssm_irq;

    int n_chk = 0;
    int n_err = 0;
    int pulse_cnt = 0;
    logic pulse_seen;
    // Register image of the multiframe being sent: fas, nfas, ra, sa4..sa8
    logic [7:0] r [8];

    always #4 clk = ~clk;

    e1_ssm_rx dut (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb), .frm_pos(frm_pos),
        .frm_byte(frm_byte), .mfa_lost(mfa_lost), .sa_sel(sa_sel), .irq_clr(irq_clr),
        .si_fas_reg(si_fas_reg), .si_nfas_reg(si_nfas_reg), .ra_reg(ra_reg),
        .sa4_reg(sa4_reg), .sa5_reg(sa5_reg), .sa6_reg(sa6_reg), .sa7_reg(sa7_reg),
        .sa8_reg(sa8_reg), .mf_pulse(mf_pulse), .ssm_q(ssm_q),
        .ssm_defined(ssm_defined), .ssm_irq(ssm_irq)
    );

    always @(negedge clk) if (mf_pulse) pulse_cnt++;

    // {msg first half, msg second half, expected q, expected irq, expected defined}
    localparam logic [13:0] VEC [8] = '{
        {4'h2, 4'h2, 4'hF, 1'b0, 1'b1},
        {4'h2, 4'h4, 4'h2, 1'b1, 1'b1},
        {4'h4, 4'h2, 4'h2, 1'b0, 1'b1},
        {4'h2, 4'h2, 4'h2, 1'b0, 1'b1},
        {4'hB, 4'hB, 4'h2, 1'b0, 1'b1},
        {4'hB, 4'h5, 4'hB, 1'b1, 1'b1},
        {4'h5, 4'h5, 4'h5, 1'b1, 1'b0},
        {4'h5, 4'h5, 4'h5, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_byte(input int f);
        int j = f / 2;
        if (f % 2 == 0) return {r[0][7-j], 7'b0011011};
        return {r[1][7-j], 1'b1, r[2][7-j], r[3][7-j], r[4][7-j], r[5][7-j], r[6][7-j], r[7][7-j]};
    endfunction

    task automatic send_frame(input int f);
        @(negedge clk);
        frm_stb  = 1'b1;
        frm_pos  = 4'(f);
        frm_byte = mk_byte(f);
        @(negedge clk);
        frm_stb  = 1'b0;
        if (f == 15) pulse_seen = mf_pulse;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends a whole multiframe from r[] and checks the capture outputs (R1, R2, R3)
    task automatic run_mf();
        pulse_seen = 1'b0;
        for (int f = 0; f < 16; f++) send_frame(f);
        check("R3 pulse after frame 15", 32'(pulse_seen), 32'd1);
        check("R1 R2 si fas", 32'(si_fas_reg), 32'(r[0]));
        check("R1 R2 si nfas", 32'(si_nfas_reg), 32'(r[1]));
        check("R1 R2 ra", 32'(ra_reg), 32'(r[2]));
        check("R1 R2 sa4", 32'(sa4_reg), 32'(r[3]));
        check("R1 R2 sa5", 32'(sa5_reg), 32'(r[4]));
        check("R1 R2 sa6", 32'(sa6_reg), 32'(r[5]));
        check("R1 R2 sa7", 32'(sa7_reg), 32'(r[6]));
        check("R1 R2 sa8", 32'(sa8_reg), 32'(r[7]));
        idle(2);
    endtask

    task automatic fill(input int seed);
        r[0] = 8'h3C ^ 8'(seed);
        r[1] = 8'hA5 + 8'(seed);
        r[2] = {4'(seed), ~4'(seed)};
        r[3] = 8'h96 ^ 8'(seed * 7);
        r[4] = 8'h5A;
        r[5] = 8'hC3 + 8'(seed * 3);
        r[6] = 8'h0F ^ 8'(seed * 5);
        r[7] = 8'h71 + 8'(seed);
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; frm_stb = 1'b0; frm_pos = '0; frm_byte = '0;
        mfa_lost = 1'b0; sa_sel = 3'd1; irq_clr = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R8 reset state
        check("R8 ssm_q reset", 32'(ssm_q), 32'hF);
        check("R8 irq reset", 32'(ssm_irq), 32'd0);
        check("R8 pulse reset", 32'(mf_pulse), 32'd0);
        check("R8 captures reset", 32'({si_fas_reg, sa5_reg, sa8_reg}), 32'd0);
        check("R10 defined at reset", 32'(ssm_defined), 32'd1);

        // Table walk on Sa5: R5, R6, R7, R10
        for (int i = 0; i < 8; i++) begin
            fill(i + 1);
            r[4] = {VEC[i][13:10], VEC[i][9:6]};
            run_mf();
            check("R6 validated level", 32'(ssm_q), 32'(VEC[i][5:2]));
            check("R7 change interrupt", 32'(ssm_irq), 32'(VEC[i][1]));
            check("R10 defined flag", 32'(ssm_defined), 32'(VEC[i][0]));
            if (VEC[i][1]) begin
                idle(4);
                check("R7 interrupt sticky", 32'(ssm_irq), 32'd1);
                clear_irq();
                check("R7 interrupt cleared", 32'(ssm_irq), 32'd0);
            end
        end
        check("R3 one pulse per multiframe", 32'(pulse_cnt), 32'd8);

        // R4: Sa8 carries code 0 while Sa5 carries 2; then selector 7 acts as Sa8
        sa_sel = 3'd4;
        fill(20); r[7] = 8'h00; r[4] = 8'h22;
        run_mf();
        check("R4 not yet accepted", 32'(ssm_q), 32'h5);
        sa_sel = 3'd7;
        fill(21); r[7] = 8'h00; r[4] = 8'h22;
        run_mf();
        check("R4 out-of-range selects Sa8", 32'(ssm_q), 32'h0);
        clear_irq();

        // R9: loss of alignment restarts agreement
        sa_sel = 3'd1;
        fill(30); r[4] = 8'h88;
        run_mf();
        @(negedge clk); mfa_lost = 1'b1;
        @(negedge clk); mfa_lost = 1'b0;
        fill(31); r[4] = 8'h88;
        run_mf();
        check("R9 agreement restarted", 32'(ssm_q), 32'h0);
        fill(32); r[4] = 8'h88;
        run_mf();
        check("R9 accepted after fresh agreement", 32'(ssm_q), 32'h8);
        check("R7 interrupt on new level", 32'(ssm_irq), 32'd1);
        clear_irq();

        // R9: loss inside a multiframe blocks its commit
        begin
            int pc;
            logic [7:0] held;
            pc = pulse_cnt;
            held = sa6_reg;
            fill(40); r[4] = 8'h88;
            for (int f = 0; f < 10; f++) send_frame(f);
            @(negedge clk); mfa_lost = 1'b1;
            @(negedge clk); mfa_lost = 1'b0;
            for (int f = 10; f < 16; f++) send_frame(f);
            idle(2);
            check("R9 no pulse for broken multiframe", 32'(pulse_cnt), 32'(pc));
            check("R9 captures held", 32'(sa6_reg), 32'(held));
            fill(41); r[4] = 8'h88;
            run_mf();
            check("R9 level unchanged", 32'(ssm_q), 32'h8);
        end

        finish_run();
    end
endmodule